// File: doc/BRIEF.md
# SPI Serial Flash Command Responder

This block is a synthesizable, device-side model of a serial NOR flash sitting behind an SPI slave port. A host drives the serial clock, the active-low chip select and the serial input; the block decodes four commands (fast read with a dummy byte, single-byte program, write enable, status read) and answers on a serial output with a separate output-enable, so the pad ring can tristate it. The byte store is a parameterised array. The 24-bit address is kept in full: it sets the read wrap point and the protection compare, and its low bits select the stored byte.

All SPI pins are sampled with the block's own clock, which must run at least six times faster than SCK. A rising SCK edge captures SI; a falling edge advances SO, so both SPI mode 0 (SCK idles low) and mode 3 (SCK idles high) work. A program takes effect only when chip select rises after a complete command. It then keeps a Busy flag set for a fixed number of clocks, and it can only turn stored 1 bits into 0 bits. A sideband preload stream fills the array with plain overwrites. Its valid/ready rule: a word is written in the cycle where `ld_valid` and `ld_ready` are both high. `ld_ready` is low while chip select is asserted, while a program runs and in the cycle a program starts. The sender must hold address and data stable until that cycle.

Top module: `spi_flash_responder`

## Requirements
- R1: After reset `so_oe` is 0, `ld_ready` is 1, and a status read returns 0x00.
- R2: Opcode 0x0B, three address bytes (high byte first, MSB first) and one dummy byte are followed by the byte stored at that address, driven MSB first on SO, each bit changed after a falling SCK edge.
- R3: While chip select stays low, read data continues byte after byte from successive addresses.
- R4: After the byte at address TOP_ADDR (default 0x1FFFFF) the read continues from address 0x000000.
- R5: Opcode 0x02, three address bytes and one data byte, completed by chip select rising, replace the stored byte with (old AND data). Busy (status bit 0) is set from that edge for PROG_CYCLES clocks.
- R6: A program that is not preceded by a write enable (opcode 0x06, taking effect when chip select rises) leaves memory and status unchanged.
- R7: While `guard_on` is 1, a program to any address at or above `guard_floor` leaves memory unchanged and the write-enable latch set.
- R8: Opcode 0x05 returns status {6'b0, write-enable latch, Busy}, repeated for every further byte. The write-enable latch clears when a program completes.
- R9: `so_oe` is 0 while chip select is high, and also during opcode, address and dummy bits and during the whole of program and write-enable commands.
- R10: If chip select rises before a command is complete, nothing is started. An unknown opcode is ignored until chip select rises.
- R11: While Busy is set, every opcode except status read is ignored.
- R12: The preload port writes `ld_data` at `ld_addr` on a valid/ready handshake. Ready is low while chip select is low or Busy is set.
- R13: Commands behave the same whether SCK idles low or high between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples all SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Drive enable for `so` |
| guard_on | input | 1 | Enables the protected region |
| guard_floor | input | ADDR_W | Lowest protected address |
| ld_valid | input | 1 | Preload word valid |
| ld_ready | output | 1 | Preload word accepted this cycle |
| ld_addr | input | IDX_W | Preload byte index |
| ld_data | input | 8 | Preload byte |

## Verification
Assertions watch, on every cycle, that a program start only happens with the write-enable latch set, outside the guarded region and never while busy. They also check that Busy follows a start, that the latch drops after completion, that the read pointer folds to zero past the top address, and that an array write only clears bits. The bench's scenarios alone can show the serial framing: the exact bit on SO after the dummy byte, the output-enable pattern over a command, the mode 3 idle level, and truncated or unknown commands that leave memory and status untouched.

// File: rtl/flr_pkg.sv
package flr_pkg;
  localparam logic [7:0] OPC_FAST_READ = 8'h0B;
  localparam logic [7:0] OPC_PROGRAM   = 8'h02;
  localparam logic [7:0] OPC_WR_ENABLE = 8'h06;
  localparam logic [7:0] OPC_STATUS    = 8'h05;

  typedef enum logic [3:0] {
    PH_OPCODE, PH_ADDR, PH_DUMMY, PH_RD_DATA, PH_PG_DATA,
    PH_PG_FULL, PH_WREN, PH_STATUS, PH_SKIP
  } phase_t;
endpackage

// File: rtl/flr_link_edges.sv
module flr_link_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel_end
);
  logic sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  // edges only count while the device is selected
  assign sck_rise = sck & ~sck_q & ~cs_n;
  assign sck_fall = ~sck & sck_q & ~cs_n;
  assign sel_end  = cs_n & ~cs_q;
endmodule

// File: rtl/flr_busy_timer.sv
module flr_busy_timer #(
  parameter int CYCLES = 600,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (start && cnt == '0)    cnt <= CW'(CYCLES);
    else if (cnt != '0)             cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  a_r5_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/flr_byte_array.sv
module flr_byte_array #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             and_mode,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= and_mode ? (mem[waddr] & wdata) : wdata;
  end

  assign rdata = mem[raddr];

  // R5: a program write may only clear bits
  a_r5_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (we && and_mode) |=> ((mem[$past(waddr)] & ~$past(wdata)) == 8'h00));
endmodule

// File: rtl/spi_flash_responder.sv
module spi_flash_responder
  import flr_pkg::*;
#(
  parameter int          DEPTH       = 256,
  parameter int          ADDR_W      = 24,
  parameter logic [23:0] TOP_ADDR    = 24'h1FFFFF,
  parameter int          PROG_CYCLES = 600,
  localparam int         IDX_W       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic              guard_on,
  input  logic [ADDR_W-1:0] guard_floor,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [IDX_W-1:0]  ld_addr,
  input  logic [7:0]        ld_data
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(TOP_ADDR);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic sck_rise, sck_fall, sel_end;
  logic busy, prog_done, prog_start, wel;
  phase_t phase;
  logic [2:0] bit_cnt;
  logic [1:0] byte_cnt;
  logic [6:0] rx;
  logic [7:0] rx_byte, tx, pdata, rd_byte, status;
  logic [ADDR_W-1:0] addr, addr_next;
  logic so_r, is_read, shifting, guarded, advance, ld_fire;

  flr_link_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sel_end(sel_end));

  flr_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy), .done(prog_done));

  flr_byte_array #(.DEPTH(DEPTH)) u_array (
    .clk(clk), .rst_n(rst_n),
    .we(prog_start | ld_fire), .and_mode(prog_start),
    .waddr(prog_start ? addr[IDX_W-1:0] : ld_addr),
    .wdata(prog_start ? pdata : ld_data),
    .raddr(addr[IDX_W-1:0]), .rdata(rd_byte));

  assign rx_byte   = {rx, si};
  assign status    = {6'b0, wel, busy};
  assign shifting  = (phase == PH_RD_DATA) || (phase == PH_STATUS);
  assign guarded   = guard_on && (addr >= guard_floor);
  assign addr_next = (addr == TOP) ? '0 : addr + ONE;
  assign advance   = sck_rise && (bit_cnt == 3'd7) &&
                     ((phase == PH_DUMMY) || (phase == PH_RD_DATA));
  assign prog_start = sel_end && (phase == PH_PG_FULL) && !busy && wel && !guarded;
  assign ld_ready  = cs_n && !busy && !prog_start;
  assign ld_fire   = ld_valid && ld_ready;
  assign so        = so_r;
  assign so_oe     = !cs_n && shifting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OPCODE; bit_cnt <= '0; byte_cnt <= '0; rx <= '0;
      addr <= '0; pdata <= '0; tx <= '0; so_r <= 1'b0; is_read <= 1'b0;
    end else if (cs_n) begin
      phase <= PH_OPCODE; bit_cnt <= '0; byte_cnt <= '0;
    end else if (sck_rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      rx      <= rx_byte[6:0];
      if (bit_cnt == 3'd7) begin
        unique case (phase)
          PH_OPCODE: begin
            if (rx_byte == OPC_STATUS) begin
              phase <= PH_STATUS; tx <= status;
            end else if (busy) phase <= PH_SKIP;
            else begin
              unique case (rx_byte)
                OPC_FAST_READ: begin phase <= PH_ADDR; is_read <= 1'b1; end
                OPC_PROGRAM:   begin phase <= PH_ADDR; is_read <= 1'b0; end
                OPC_WR_ENABLE: phase <= PH_WREN;
                default:       phase <= PH_SKIP;
              endcase
            end
          end
          PH_ADDR: begin
            addr     <= {addr[ADDR_W-9:0], rx_byte};
            byte_cnt <= byte_cnt + 2'd1;
            if (byte_cnt == 2'd2) phase <= is_read ? PH_DUMMY : PH_PG_DATA;
          end
          PH_DUMMY:   begin phase <= PH_RD_DATA; tx <= rd_byte; addr <= addr_next; end
          PH_RD_DATA: begin tx <= rd_byte; addr <= addr_next; end
          PH_PG_DATA: begin pdata <= rx_byte; phase <= PH_PG_FULL; end
          PH_STATUS:  tx <= status;
          default: ;
        endcase
      end
    end else if (sck_fall && shifting) begin
      so_r <= tx[7];
      tx   <= {tx[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       wel <= 1'b0;
    else if (prog_done)                               wel <= 1'b0;
    else if (sel_end && phase == PH_WREN && !busy)    wel <= 1'b1;
  end

  a_r6_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wel);
  a_r7_start_unguarded: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !(guard_on && addr >= guard_floor));
  a_r8_wel_drops: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !wel);
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && addr == TOP) |=> (addr == '0));
  a_r11_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_start);
  a_r12_no_load_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !ld_ready);
endmodule

// File: tb/tb_spi_flash_responder.sv
module tb_spi_flash_responder;
  localparam int          DEPTH = 256;
  localparam logic [23:0] TOPA  = 24'h1FFFFF;
  localparam int          PCYC  = 600;
  localparam int          HALF  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, ld_ready, ld_valid = 1'b0, guard_on = 1'b0;
  logic [23:0] guard_floor = 24'h0;
  logic [7:0] ld_addr = '0, ld_data = '0;

  logic [7:0] exp_mem [DEPTH];
  logic exp_wel = 1'b0;
  logic mode3 = 1'b0;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_flash_responder #(.DEPTH(DEPTH), .TOP_ADDR(TOPA), .PROG_CYCLES(PCYC)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
    .guard_on(guard_on), .guard_floor(guard_floor), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data));

  function automatic logic [7:0] init_val(int i);
    return (i % 4 == 0) ? 8'hFF : 8'(i * 37 + 11);
  endfunction

  function automatic logic [23:0] next_addr(logic [23:0] a);
    return (a == TOPA) ? 24'h0 : a + 24'd1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, input int nbits, input int oe_exp,
                      input string req, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); sck = 1'b0; si = b[7-i];
      repeat (HALF) @(negedge clk);
      got = {got[6:0], so};
      if (oe_exp >= 0) chk(req, {31'b0, so_oe}, oe_exp);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic sel_begin();
    @(negedge clk); sck = mode3;
    repeat (2) @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sel_end();
    @(negedge clk); sck = mode3;
    repeat (2) @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 idle oe", {31'b0, so_oe}, 0);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [23:0] a, input string req);
    logic [7:0] g;
    xfer(op, 8, 0, req, g);
    xfer(a[23:16], 8, 0, req, g);
    xfer(a[15:8], 8, 0, req, g);
    xfer(a[7:0], 8, 0, req, g);
  endtask

  task automatic do_read(input logic [23:0] a0, input int n, input string req);
    logic [7:0] g;
    logic [23:0] a = a0;
    sel_begin();
    send_hdr(8'h0B, a0, "R9 read header");
    xfer(8'h00, 8, 0, "R9 dummy", g);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, 1, "R2 data oe", g);
      chk(req, {24'b0, g}, {24'b0, exp_mem[a[7:0]]});
      a = next_addr(a);
    end
    sel_end();
  endtask

  task automatic rd_status(input int nbytes, output logic [7:0] s);
    logic [7:0] g;
    sel_begin();
    xfer(8'h05, 8, 0, "R9 status opcode", g);
    for (int k = 0; k < nbytes; k++) xfer(8'h00, 8, 1, "R8 status oe", s);
    sel_end();
  endtask

  task automatic do_wren();
    logic [7:0] g;
    sel_begin(); xfer(8'h06, 8, 0, "R9 wren", g); sel_end();
    exp_wel = 1'b1;
  endtask

  task automatic do_prog(input logic [23:0] a, input logic [7:0] d, output bit started);
    logic [7:0] g;
    sel_begin();
    send_hdr(8'h02, a, "R9 program header");
    xfer(d, 8, 0, "R9 program data", g);
    sel_end();
    started = exp_wel && !(guard_on && a >= guard_floor);
    if (started) exp_mem[a[7:0]] = exp_mem[a[7:0]] & d;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rd_status(1, s);
      if (!s[0]) break;
    end
  endtask

  task automatic load_byte(input int i, input logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = 8'(i); ld_data = d;
    while (!ld_ready) @(negedge clk);
    @(negedge clk); ld_valid = 1'b0;
    exp_mem[i] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, g;
    bit st;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 so_oe", {31'b0, so_oe}, 0);
    chk("R1 ld_ready", {31'b0, ld_ready}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ld_ready after release", {31'b0, ld_ready}, 1);
    for (int i = 0; i < DEPTH; i++) load_byte(i, init_val(i));
    rd_status(1, s);
    chk("R1 status", {24'b0, s}, 32'h00);

    // R2/R3: mode 0 read of several bytes
    do_read(24'h000010, 4, "R3 stream data");
    do_read(24'h0A0033, 1, "R2 first byte");
    // R4 + R13: wrap in mode 3
    mode3 = 1'b1;
    do_read(TOPA - 24'd1, 4, "R4 wrap data");
    mode3 = 1'b0;

    // R6: program with no write enable
    do_prog(24'h000021, 8'h00, st);
    rd_status(1, s);
    chk("R6 status", {24'b0, s}, 32'h00);
    do_read(24'h000021, 1, "R6 unchanged");

    // R5/R8/R11: accepted program
    do_wren();
    rd_status(2, s);
    chk("R8 wel set, repeated", {24'b0, s}, 32'h02);
    do_prog(24'h000024, 8'h5A, st);
    rd_status(1, s);
    chk("R5 busy", {24'b0, s}, 32'h03);
    chk("R12 not ready busy", {31'b0, ld_ready}, 0);
    sel_begin();
    send_hdr(8'h0B, 24'h000024, "R11 read header");
    xfer(8'h00, 8, 0, "R11 dummy", g);
    xfer(8'h00, 8, 0, "R11 read ignored", g);
    sel_end();
    wait_idle();
    exp_wel = 1'b0;
    rd_status(1, s);
    chk("R8 wel cleared", {24'b0, s}, 32'h00);
    do_read(24'h000024, 1, "R5 AND result");

    // R7: guarded region
    guard_on = 1'b1; guard_floor = 24'h000080;
    do_wren();
    do_prog(24'h000090, 8'h00, st);
    rd_status(1, s);
    chk("R7 no busy, wel kept", {24'b0, s}, 32'h02);
    do_read(24'h000090, 1, "R7 unchanged");
    do_prog(24'h000041, 8'h0F, st);
    wait_idle();
    exp_wel = 1'b0;
    do_read(24'h000041, 1, "R7 below floor programmed");
    guard_on = 1'b0;

    // R10: truncated program and unknown opcode
    do_wren();
    sel_begin();
    send_hdr(8'h02, 24'h000030, "R10 header");
    xfer(8'h00, 4, 0, "R10 partial", g);
    sel_end();
    rd_status(1, s);
    chk("R10 partial not started", {24'b0, s}, 32'h02);
    do_read(24'h000030, 1, "R10 memory kept");
    sel_begin();
    xfer(8'hA5, 8, 0, "R10 unknown", g);
    xfer(8'h02, 8, 0, "R10 unknown tail", g);
    sel_end();
    rd_status(1, s);
    chk("R10 status kept", {24'b0, s}, 32'h02);

    // constrained random mix
    for (int it = 0; it < 14; it++) begin
      logic [23:0] a;
      int kind;
      a = 24'($urandom) & TOPA;
      kind = int'($urandom % 3);
      mode3 = 1'($urandom);
      if (kind == 0) do_read(a, 1 + int'($urandom % 5), "R3 random read");
      else if (kind == 1) begin
        if ($urandom % 4 != 0) do_wren();
        do_prog(a, 8'($urandom), st);
        if (st) begin wait_idle(); exp_wel = 1'b0; end
        do_read(a, 1, "R5 random program");
      end else begin
        rd_status(1, s);
        chk("R8 random status", {24'b0, s}, {30'b0, exp_wel, 1'b0});
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule